// File: doc/BRIEF.md
# Multi-Input Tamper Detector

This block monitors a set of external tamper pins and one internal tamper event strobe. It merges every detection into one sticky tamper flag, which also drives a shared interrupt request. Each pin has its own polarity bit, which picks whether a rising or a falling transition counts. Each pin also has its own two-bit action code, which either ignores the pin or lets it set the flag. In the wake action the flag is set and nothing else happens. No timestamp is requested.

Each raw pin level passes through a multi-flop synchronizer. An edge detector follows it. The detector keeps following the pin's level while the pin is switched off. Because of this, a change of action never turns a level seen long ago into a detection. A short settling window after reset keeps pins that already sit at their active level from firing. A sticky status vector records which sources raised the flag. Software clears the flag and the status vector together with a one-cycle strobe.

Top module: `tamper_detector`

## Requirements
- R1: After reset, `tamper_flag`, `tamper_irq` and every bit of `src_status` are 0.
- R2: A pin whose action is wake and whose polarity bit is 1 sets `tamper_flag` and its `src_status` bit (bit i for pin i) on a rising pin level. Both become visible after the third rising clock edge that follows the pin change. A falling level on that pin is ignored.
- R3: A pin whose action is wake and whose polarity bit is 0 reacts to a falling pin level with the same timing as R2. A rising level on that pin is ignored.
- R4: The action field of pin i sits at `pin_act[2i+1:2i]`. Code 2'b01 is wake. Code 2'b00 is off. The codes 2'b10 and 2'b11 are reserved and behave as off. A pin in any non-wake code never sets the flag or its status bit.
- R5: A high `evt_strobe` while `evt_en` is 1 sets `tamper_flag` and `src_status[NUM_PINS]` after the next rising clock edge. While `evt_en` is 0 the strobe is ignored.
- R6: `tamper_flag` and `src_status` hold their values until `flag_clr` is high at a clock edge. After that edge both read 0 when no new detection occurs in that cycle. `tamper_flag` is 1 exactly when `src_status` is non-zero.
- R7: When `flag_clr` and a new detection fall in the same cycle, `tamper_flag` stays 1. `src_status` then holds only the sources detected in that cycle.
- R8: `tamper_irq` equals `tamper_flag` in every cycle.
- R9: Pin level changes that happen while a pin is off are not reported when the pin is later switched to wake. Only a qualifying transition after the switch sets the flag.
- R10: During the first NUM_PINS-independent settling window of SYNC_STAGES+2 cycles after reset, no pin detection occurs. A pin held at its active level through reset therefore never fires.
- R11: Transitions on several armed pins in the same cycle set all of their `src_status` bits together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_raw | input | NUM_PINS | Asynchronous tamper pin levels |
| evt_strobe | input | 1 | Internal tamper event, one-cycle pulse |
| pin_pol | input | NUM_PINS | Per-pin polarity: 1 rising, 0 falling |
| pin_act | input | 2*NUM_PINS | Per-pin action code, 2 bits each |
| evt_en | input | 1 | Enables the internal event source |
| flag_clr | input | 1 | Clears flag and status |
| tamper_flag | output | 1 | Sticky tamper flag |
| tamper_irq | output | 1 | Interrupt request |
| src_status | output | NUM_PINS+1 | Sticky per-source record, top bit is the event |

## Verification
A pin change driven between clock edges needs three rising edges before the flag shows it: two synchronizer stages and then the flag register. The event strobe and the clear strobe act on the first edge. The bench drives all inputs on falling edges and then waits exactly that number of falling edges before it samples, so each positive check lands on the first cycle the result is due. The bench also checks one cycle earlier that a pin result is not yet visible. Checks that something is ignored wait at least one cycle longer than the pin delay before they read the flag and the status.

// File: rtl/tamper_pkg.sv
// Shared types for the tamper detector: per-pin action encoding and helper.
package tamper_pkg;

    // Two-bit per-pin action code; codes other than WAKE disable the pin.
    typedef enum logic [1:0] {
        TACT_OFF   = 2'b00,
        TACT_WAKE  = 2'b01,
        TACT_RSV2  = 2'b10,
        TACT_RSV3  = 2'b11
    } tamp_act_e;

    // True when an action code enables detection.
    function automatic logic act_is_wake(input logic [1:0] code);
        return code == TACT_WAKE;
    endfunction

endpackage

// File: rtl/tamper_sync.sv
// Multi-flop synchronizer for one asynchronous pin level.
// Assumes STAGES >= 2; the output resets to 0 and lags the input by STAGES edges.
module tamper_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/tamper_edge.sv
// Polarity-selected edge detector for one synchronized tamper pin.
// The previous-level register follows the pin at all times, even when the
// pin is off, so that switching to wake cannot report a stale level.
// Detection is allowed only when the pin was armed in the previous cycle
// and is still in wake now; arming also waits for the global settle flag.
module tamper_edge
    import tamper_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       settled,
    input  logic       level,
    input  logic       pol_rise,
    input  logic [1:0] act,
    output logic       hit
);
    logic prev_q;
    logic armed_q;
    logic wake_now;
    logic rise_seen;
    logic fall_seen;

    assign wake_now  = act_is_wake(act);
    assign rise_seen = level & ~prev_q;
    assign fall_seen = ~level & prev_q;

    // Track the last synchronized level regardless of action.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    // Arm one cycle after the pin is in wake and the inputs have settled.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= settled & wake_now;
    end

    // Qualify the edge with polarity, arming and the current action.
    always_comb begin
        hit = 1'b0;
        if (armed_q && wake_now) begin
            hit = pol_rise ? rise_seen : fall_seen;
        end
    end
endmodule

// File: rtl/tamper_collect.sv
// Sticky collector: merges per-source hits into one flag and a status vector.
// A new hit in the same cycle as a clear wins over the clear.
module tamper_collect #(
    parameter int N_SRC = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] hits,
    input  logic             clr,
    output logic             flag,
    output logic [N_SRC-1:0] status
);
    logic [N_SRC-1:0] status_nxt;

    // Keep old sources unless cleared, then add the new ones.
    always_comb begin
        status_nxt = hits | (clr ? '0 : status);
    end

    // Register status and derive the flag from the same next value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
            flag   <= 1'b0;
        end else begin
            status <= status_nxt;
            flag   <= |status_nxt;
        end
    end
endmodule

// File: rtl/tamper_detector.sv
// Top of the multi-input tamper detector.
// Per pin: synchronizer, then polarity/action qualified edge detector.
// The internal event source is gated by evt_en. All hits feed one sticky
// collector that drives the flag, the interrupt request and the status.
// Assumes flag_clr, evt_strobe and the settings are synchronous to clk.
module tamper_detector
    import tamper_pkg::*;
#(
    parameter int NUM_PINS    = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   pin_raw,
    input  logic                  evt_strobe,
    input  logic [NUM_PINS-1:0]   pin_pol,
    input  logic [2*NUM_PINS-1:0] pin_act,
    input  logic                  evt_en,
    input  logic                  flag_clr,
    output logic                  tamper_flag,
    output logic                  tamper_irq,
    output logic [NUM_PINS:0]     src_status
);
    localparam int N_SRC    = NUM_PINS + 1;
    localparam int SETTLE   = SYNC_STAGES + 1;
    localparam int CNT_W    = $clog2(SETTLE + 1);
    localparam logic [CNT_W-1:0] SETTLE_C = CNT_W'(SETTLE);

    logic [CNT_W-1:0]    settle_cnt_q;
    logic                settled;
    logic [NUM_PINS-1:0] pin_sync;
    logic [N_SRC-1:0]    hit_vec;

    // Count cycles after reset until synchronizers and edge history are valid.
    always_ff @(posedge clk) begin
        if (!rst_n)                 settle_cnt_q <= '0;
        else if (!settled)          settle_cnt_q <= settle_cnt_q + 1'b1;
    end

    assign settled = (settle_cnt_q == SETTLE_C);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_PINS; gi++) begin : g_pin
            tamper_sync #(
                .STAGES (SYNC_STAGES)
            ) u_sync (
                .clk     (clk),
                .rst_n   (rst_n),
                .d_async (pin_raw[gi]),
                .q_sync  (pin_sync[gi])
            );

            tamper_edge u_edge (
                .clk      (clk),
                .rst_n    (rst_n),
                .settled  (settled),
                .level    (pin_sync[gi]),
                .pol_rise (pin_pol[gi]),
                .act      (pin_act[2*gi +: 2]),
                .hit      (hit_vec[gi])
            );
        end
    endgenerate

    // Internal event source, enabled by its own bit.
    assign hit_vec[NUM_PINS] = evt_en & evt_strobe;

    tamper_collect #(
        .N_SRC (N_SRC)
    ) u_collect (
        .clk    (clk),
        .rst_n  (rst_n),
        .hits   (hit_vec),
        .clr    (flag_clr),
        .flag   (tamper_flag),
        .status (src_status)
    );

    assign tamper_irq = tamper_flag;
endmodule

// File: rtl/tamper_detector_chk.sv
// Assertion checker for tamper_detector, attached by bind.
module tamper_detector_chk #(
    parameter int NUM_PINS = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [2*NUM_PINS-1:0] pin_act,
    input logic                  evt_en,
    input logic                  evt_strobe,
    input logic                  flag_clr,
    input logic [NUM_PINS:0]     hit_vec,
    input logic                  tamper_flag,
    input logic                  tamper_irq,
    input logic [NUM_PINS:0]     src_status
);
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        tamper_flag && !flag_clr |=> tamper_flag); // R6
    AST_FLAG_TRACKS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        tamper_flag == (src_status != '0)); // R6
    AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr && (hit_vec == '0) |=> !tamper_flag && (src_status == '0)); // R6
    AST_HIT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr && (hit_vec != '0) |=> tamper_flag); // R7
    AST_IRQ_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tamper_irq) |-> $past(hit_vec != '0)); // R8
    AST_EVT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(src_status[NUM_PINS]) |-> $past(evt_en && evt_strobe)); // R5

    genvar gi;
    generate
        for (gi = 0; gi < NUM_PINS; gi++) begin : g_pin_chk
            AST_OFF_PIN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(src_status[gi]) |-> $past(pin_act[2*gi +: 2] == 2'b01)); // R4
        end
    endgenerate
endmodule

bind tamper_detector tamper_detector_chk #(
    .NUM_PINS (NUM_PINS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_act     (pin_act),
    .evt_en      (evt_en),
    .evt_strobe  (evt_strobe),
    .flag_clr    (flag_clr),
    .hit_vec     (hit_vec),
    .tamper_flag (tamper_flag),
    .tamper_irq  (tamper_irq),
    .src_status  (src_status)
);

// File: tb/sim_tamper_detector.sv
// Directed bench for tamper_detector; inputs change on falling edges.
module sim_tamper_detector;
    localparam int NP = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_raw = '0;
    logic          evt_strobe = 1'b0;
    logic [NP-1:0] pin_pol = '0;
    logic [2*NP-1:0] pin_act = '0;
    logic          evt_en = 1'b0;
    logic          flag_clr = 1'b0;
    logic          tamper_flag;
    logic          tamper_irq;
    logic [NP:0]   src_status;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2 clk = ~clk;

    tamper_detector #(.NUM_PINS(NP), .SYNC_STAGES(2)) u0 (
        .clk, .rst_n, .pin_raw, .evt_strobe, .pin_pol, .pin_act,
        .evt_en, .flag_clr, .tamper_flag, .tamper_irq, .src_status
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_state(input string req, input logic f, input logic [NP:0] st);
        check({req, " flag"}, {7'd0, tamper_flag}, {7'd0, f});
        check({req, " irq"}, {7'd0, tamper_irq}, {7'd0, f});   // R8
        check({req, " status"}, {2'd0, src_status}, {2'd0, st});
    endtask

    task automatic set_act(input int p, input logic [1:0] code);
        pin_act[2*p +: 2] = code;
    endtask

    task automatic do_clear();
        flag_clr = 1'b1;
        step(1);
        flag_clr = 1'b0;
    endtask

    task automatic t_reset();   // R1
        check_state("R1 reset", 1'b0, '0);
    endtask

    task automatic t_rise();    // R2
        pin_pol[0] = 1'b1; set_act(0, 2'b01); step(2);
        pin_raw[0] = 1'b1;
        step(2); check_state("R2 not yet", 1'b0, '0);
        step(1); check_state("R2 rise", 1'b1, 6'b000001);
        do_clear(); check_state("R6 cleared", 1'b0, '0);
        pin_raw[0] = 1'b0; step(5);
        check_state("R2 fall ignored", 1'b0, '0);
    endtask

    task automatic t_fall();    // R3
        pin_pol[1] = 1'b0; set_act(1, 2'b01); step(2);
        pin_raw[1] = 1'b1; step(5);
        check_state("R3 rise ignored", 1'b0, '0);
        pin_raw[1] = 1'b0; step(3);
        check_state("R3 fall", 1'b1, 6'b000010);
        do_clear();
    endtask

    task automatic t_off();     // R4
        for (int k = 0; k < 4; k++) begin
            if (k == 1) continue;
            pin_pol[2] = 1'b1; set_act(2, k[1:0]); step(2);
            pin_raw[2] = 1'b1; step(5);
            pin_raw[2] = 1'b0; step(5);
            check_state("R4 non-wake code", 1'b0, '0);
        end
        set_act(2, 2'b00);
    endtask

    task automatic t_evt();     // R5, R6
        evt_en = 1'b0; evt_strobe = 1'b1; step(1); evt_strobe = 1'b0; step(2);
        check_state("R5 disabled", 1'b0, '0);
        evt_en = 1'b1; evt_strobe = 1'b1; step(1); evt_strobe = 1'b0;
        check_state("R5 event", 1'b1, 6'b100000);
        step(10); check_state("R6 sticky", 1'b1, 6'b100000);
        do_clear(); check_state("R6 clear", 1'b0, '0);
    endtask

    task automatic t_simul();   // R7
        pin_pol[3] = 1'b1; set_act(3, 2'b01); step(2);
        pin_raw[3] = 1'b1; step(3);
        check_state("R7 setup", 1'b1, 6'b001000);
        flag_clr = 1'b1; evt_strobe = 1'b1; step(1);
        flag_clr = 1'b0; evt_strobe = 1'b0;
        check_state("R7 clear vs hit", 1'b1, 6'b100000);
        do_clear();
    endtask

    task automatic t_multi();   // R11
        pin_pol[3] = 1'b0; step(2);
        pin_raw[0] = 1'b1; pin_raw[3] = 1'b0; step(3);
        check_state("R11 two pins", 1'b1, 6'b001001);
        do_clear();
    endtask

    task automatic t_rearm();   // R9
        pin_pol[4] = 1'b1; set_act(4, 2'b00); step(1);
        pin_raw[4] = 1'b1; step(5);
        set_act(4, 2'b01); step(6);
        check_state("R9 no stale hit", 1'b0, '0);
        pin_raw[4] = 1'b0; step(5);
        pin_raw[4] = 1'b1; step(3);
        check_state("R9 fresh hit", 1'b1, 6'b010000);
        do_clear();
    endtask

    task automatic t_settle();  // R10
        pin_act = '0; pin_pol = '1; pin_raw = '1; step(2);
        set_act(0, 2'b01); set_act(4, 2'b01);
        rst_n = 1'b0; step(3); rst_n = 1'b1;
        step(8); check_state("R10 settle", 1'b0, '0);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual timeout expected finish");
                report();
            end
        end
    end

    initial begin
        step(3); rst_n = 1'b1; step(6);
        t_reset();
        t_rise();
        t_fall();
        t_off();
        t_evt();
        t_simul();
        t_multi();
        t_rearm();
        t_settle();
        report();
    end
endmodule